// File: doc/BRIEF.md
# Swap-Context Multi-Channel DMA Engine

This block is a multi-channel DMA engine that keeps the working state of only one channel inside the block. The descriptors for all channels live in system RAM, in a table whose start address software writes into a register. Each peripheral has a trigger line. A trigger asks for one data beat on that channel. When the triggered channel is not the one held in the engine, the engine first stores the held state back into its table slot. It then reads the state of the new channel from the table, and only after that moves the beat.

Software fills the descriptor table in RAM, writes the table address, and enables the channels it wants in a mask register. The engine then runs on its own from the trigger lines. When a channel has used up its length, it clears its own enable. If the channel's descriptor asks for an interrupt, the channel also sets a done interrupt line, which stays high until software clears it. A trigger that arrives while the same channel still has an unserved request sets an overrun flag for that channel.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset, no memory request is made, all done lines are low, and every register reads back as zero.
- R2: Channel n's descriptor starts at table base + 16·n. It holds four words at byte offsets 0, 4, 8 and 12: source address, destination address, remaining beat count and configuration. The table base is 16-byte aligned, so its low four bits are ignored on write and read back as zero.
- R3: When no channel is held, the first trigger causes four descriptor reads and no descriptor writes. Later triggers on the held channel cause no descriptor traffic at all.
- R4: When a different channel must run, the engine writes the four words of the held channel to that channel's slot, in word order and with their current values. It then reads the four words of the new channel.
- R5: The configuration word has these fields: bit 0 enables the channel, bit 1 enables source increment, bit 2 enables destination increment, bits 4:3 give the beat size (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes), and bit 5 enables the interrupt.
- R6: Each beat is one word-aligned read followed by one word-aligned write. The data comes from byte lane src[1:0] and goes to byte lane dst[1:0], and the byte enables cover exactly the beat size. Addresses are assumed to be aligned to the beat size.
- R7: After each beat, the beat count drops by one. Each address whose increment bit is set then advances by the beat size, and the other address stays where it is.
- R8: When the beat count reaches zero, the channel's enable-mask bit clears and the enable bit of its held configuration clears. If bit 5 is set, its done line also goes high. The done line stays high until software writes a 1 to its bit at register 2.
- R9: When several channels have requests waiting, the lowest-numbered channel is served first, one channel at a time.
- R10: A trigger on a channel that still has an unserved request sets that channel's overrun bit, which reads at register 3 and is cleared by writing a 1 to it.
- R11: A trigger on a channel whose enable-mask bit is 0 is ignored. It causes no memory traffic and no overrun.
- R12: A loaded descriptor whose enable bit is 0, or whose beat count is 0, causes no data beat, and its mask bit stays set.
- R13: The register map is: address 0 holds the table base, address 1 the channel enable mask, address 2 the done flags (write 1 to clear) and address 3 the overrun flags (write 1 to clear). Reads are zero-extended.
- R14: Once the engine raises a memory request, it holds the request, the address and the direction unchanged until the memory acknowledges it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | NCH | One-cycle request pulse per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Byte enables for a write |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge, completes the request |
| done_irq | output | NCH | Per-channel done interrupt lines |

## Verification
The hardest state to reach from the ports is a request that is already waiting while the engine is still busy, because the engine takes a request in the cycle right after it is recorded. The bench holds one trigger line high for three cycles in a row. The first pulse records the request, the second lands in the cycle when the engine takes it, and the third arrives while the engine is busy fetching the descriptor, which sets the overrun flag. The bench checks the swap order by reading a log of memory transactions. It also runs one swap with a memory that delays its acknowledge, so that the request-hold rule is checked under real stalls.

// File: rtl/dma_pkg.sv
// Package: shared constants, state encoding and helpers for the DMA engine.
// Assumes a 32-bit data bus and 32-bit descriptor words.
package dma_pkg;

    localparam int WORD_W   = 32;
    localparam int DESC_WRDS = 4;

    // Word order inside a descriptor slot
    localparam int W_SRC = 0;
    localparam int W_DST = 1;
    localparam int W_LEN = 2;
    localparam int W_CFG = 3;

    // Configuration bit positions
    localparam int CFG_EN   = 0;
    localparam int CFG_SINC = 1;
    localparam int CFG_DINC = 2;
    localparam int CFG_SZ   = 3;   // two bits: CFG_SZ+1 : CFG_SZ
    localparam int CFG_IE   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_FETCH,
        ST_CHECK,
        ST_READ,
        ST_WRITE
    } dma_state_e;

    // Number of bytes moved by one beat for a size code
    function automatic logic [2:0] beat_step(input logic [1:0] sz);
        case (sz)
            2'd0:    beat_step = 3'd1;
            2'd1:    beat_step = 3'd2;
            default: beat_step = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_req_arb.sv
// Request tracker and fixed-priority picker.
// Holds one pending bit per channel, flags overruns, and offers the
// lowest-numbered enabled pending channel. Assumes trig is a pulse per
// request; 'take' consumes the currently offered channel.
module dma_req_arb #(
    parameter int NCH = 12,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] trig,
    input  logic [NCH-1:0] en_mask,
    input  logic           take,
    output logic           gnt_valid,
    output logic [CHW-1:0] gnt_id,
    output logic [NCH-1:0] ovr_set
);

    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] take_vec;

    // Decode the consumed request into a channel vector
    always_comb begin
        take_vec = '0;
        if (take) take_vec[gnt_id] = 1'b1;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        // Per-channel pending bit: set by trigger, cleared when taken or disabled
        always_ff @(posedge clk) begin
            if (!rst_n) pend_q[g] <= 1'b0;
            else        pend_q[g] <= ((pend_q[g] & ~take_vec[g]) | trig[g]) & en_mask[g];
        end
        // Overrun when a new trigger meets an unserved request
        assign ovr_set[g] = trig[g] & pend_q[g] & ~take_vec[g] & en_mask[g];
    end

    // Lowest channel number wins
    always_comb begin
        gnt_id = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_q[i] && en_mask[i]) gnt_id = CHW'(i);
        end
    end

    assign gnt_valid = |(pend_q & en_mask);

endmodule

// File: rtl/dma_csr.sv
// Software-visible registers: table base, channel enable mask, done flags
// and overrun flags. Done/overrun are write-1-to-clear; hardware sets win.
// Hardware completion clears the enable bit after any software write.
// Assumes NCH <= 32 and AW <= 32.
module dma_csr #(
    parameter int NCH = 12,
    parameter int AW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [1:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic [NCH-1:0] en_clr,
    input  logic [NCH-1:0] done_set,
    input  logic [NCH-1:0] ovr_set,
    output logic [AW-1:0]  base_o,
    output logic [NCH-1:0] en_mask_o,
    output logic [NCH-1:0] done_o,
    output logic [NCH-1:0] ovr_o
);

    logic [AW-5:0]  base_q;
    logic [NCH-1:0] en_q;
    logic [NCH-1:0] done_q;
    logic [NCH-1:0] ovr_q;
    logic [NCH-1:0] wr_bits;

    assign wr_bits = reg_wdata[NCH-1:0];

    // Register update from software writes and hardware events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= '0;
            done_q <= '0;
            ovr_q  <= '0;
        end else begin
            if (reg_wr && reg_addr == 2'd0) base_q <= reg_wdata[AW-1:4];
            en_q   <= ((reg_wr && reg_addr == 2'd1) ? wr_bits : en_q) & ~en_clr;
            done_q <= (done_q & ~((reg_wr && reg_addr == 2'd2) ? wr_bits : '0)) | done_set;
            ovr_q  <= (ovr_q  & ~((reg_wr && reg_addr == 2'd3) ? wr_bits : '0)) | ovr_set;
        end
    end

    // Read multiplexer
    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = 32'({base_q, 4'b0000});
            2'd1:    reg_rdata = 32'(en_q);
            2'd2:    reg_rdata = 32'(done_q);
            default: reg_rdata = 32'(ovr_q);
        endcase
    end

    assign base_o    = {base_q, 4'b0000};
    assign en_mask_o = en_q;
    assign done_o    = done_q;
    assign ovr_o     = ovr_q;

endmodule

// File: rtl/dma_beat_lane.sv
// Byte-lane steering for one beat on a 32-bit little-endian bus.
// Extracts a right-aligned beat from the read word at the source lane, and
// places a beat at the destination lane with matching byte enables.
// Assumes addresses aligned to the beat size.
module dma_beat_lane (
    input  logic [31:0] rd_word,
    input  logic [1:0]  src_off,
    input  logic [1:0]  dst_off,
    input  logic [1:0]  size,
    input  logic [31:0] beat_i,
    output logic [31:0] beat_o,
    output logic [31:0] wdata_o,
    output logic [3:0]  be_o
);

    logic [31:0] data_mask;
    logic [3:0]  be_base;

    // Size code to data mask and unshifted byte enables
    always_comb begin
        case (size)
            2'd0:    begin data_mask = 32'h0000_00FF; be_base = 4'b0001; end
            2'd1:    begin data_mask = 32'h0000_FFFF; be_base = 4'b0011; end
            default: begin data_mask = 32'hFFFF_FFFF; be_base = 4'b1111; end
        endcase
    end

    // Steer the data toward and away from the lanes
    always_comb begin
        beat_o  = (rd_word >> {src_off, 3'b000}) & data_mask;
        wdata_o = (beat_i & data_mask) << {dst_off, 3'b000};
        be_o    = be_base << dst_off;
    end

endmodule

// File: rtl/dma_desc_engine.sv
// DMA engine with RAM-resident channel descriptors.
// Holds one channel's context on chip. A trigger on another channel makes
// the engine store the held context to its RAM slot and fetch the new one
// before moving a single beat. Assumes a memory that holds read data valid
// with its acknowledge and accepts a request only when it acknowledges.
module dma_desc_engine
    import dma_pkg::*;
#(
    parameter int NCH = 12,
    parameter int AW  = 32,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] trig,
    input  logic           reg_wr,
    input  logic [1:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [31:0]    mem_wdata,
    output logic [3:0]     mem_be,
    input  logic [31:0]    mem_rdata,
    input  logic           mem_ack,
    output logic [NCH-1:0] done_irq
);

    dma_state_e                    st_q;
    logic [1:0]                    wcnt_q;
    logic [CHW-1:0]                held_ch_q;
    logic                          held_v_q;
    logic [CHW-1:0]                tgt_q;
    logic [DESC_WRDS-1:0][WORD_W-1:0] ctx_q;
    logic [31:0]                   beat_q;

    logic [AW-1:0]  base;
    logic [NCH-1:0] en_mask;
    logic [NCH-1:0] ovr_flags;
    logic [NCH-1:0] ovr_set;
    logic [NCH-1:0] en_clr;
    logic [NCH-1:0] done_set;
    logic           gnt_valid;
    logic [CHW-1:0] gnt_id;
    logic           take;
    logic [31:0]    beat_rd;
    logic [31:0]    lane_wdata;
    logic [3:0]     lane_be;
    logic [1:0]     sz;
    logic [31:0]    step;
    logic           last_beat;
    logic           xfer_done;
    logic [AW-1:0]  slot_ch;
    logic [AW-1:0]  slot_addr;

    dma_csr #(.NCH(NCH), .AW(AW)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .en_clr    (en_clr),
        .done_set  (done_set),
        .ovr_set   (ovr_set),
        .base_o    (base),
        .en_mask_o (en_mask),
        .done_o    (done_irq),
        .ovr_o     (ovr_flags)
    );

    dma_req_arb #(.NCH(NCH)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .en_mask   (en_mask),
        .take      (take),
        .gnt_valid (gnt_valid),
        .gnt_id    (gnt_id),
        .ovr_set   (ovr_set)
    );

    dma_beat_lane u_lane (
        .rd_word (mem_rdata),
        .src_off (ctx_q[W_SRC][1:0]),
        .dst_off (ctx_q[W_DST][1:0]),
        .size    (sz),
        .beat_i  (beat_q),
        .beat_o  (beat_rd),
        .wdata_o (lane_wdata),
        .be_o    (lane_be)
    );

    assign sz        = ctx_q[W_CFG][CFG_SZ+1:CFG_SZ];
    assign step      = 32'(beat_step(sz));
    assign take      = (st_q == ST_IDLE) && gnt_valid;
    assign last_beat = (ctx_q[W_LEN] == 32'd1);
    assign xfer_done = (st_q == ST_WRITE) && mem_ack;

    // Descriptor slot address for the channel being stored or fetched
    always_comb begin
        slot_ch   = AW'((st_q == ST_SAVE) ? held_ch_q : tgt_q);
        slot_addr = base + (slot_ch << 4) + AW'({wcnt_q, 2'b00});
    end

    // Completion events for the held channel
    always_comb begin
        en_clr   = '0;
        done_set = '0;
        if (xfer_done && last_beat) begin
            en_clr[held_ch_q]   = 1'b1;
            done_set[held_ch_q] = ctx_q[W_CFG][CFG_IE];
        end
    end

    // Memory master outputs per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = 4'b0000;
        case (st_q)
            ST_SAVE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot_addr;
                mem_wdata = ctx_q[wcnt_q];
                mem_be    = 4'b1111;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = slot_addr;
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = {ctx_q[W_SRC][AW-1:2], 2'b00};
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ctx_q[W_DST][AW-1:2], 2'b00};
                mem_wdata = lane_wdata;
                mem_be    = lane_be;
            end
            default: ;
        endcase
    end

    // Sequencer: swap context as needed, then move one beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            wcnt_q    <= '0;
            held_ch_q <= '0;
            held_v_q  <= 1'b0;
            tgt_q     <= '0;
            ctx_q     <= '0;
            beat_q    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    wcnt_q <= '0;
                    if (gnt_valid) begin
                        tgt_q <= gnt_id;
                        if (held_v_q && held_ch_q == gnt_id) st_q <= ST_CHECK;
                        else if (held_v_q)                   st_q <= ST_SAVE;
                        else                                  st_q <= ST_FETCH;
                    end
                end
                ST_SAVE: begin
                    if (mem_ack) begin
                        wcnt_q <= wcnt_q + 2'd1;
                        if (wcnt_q == 2'd3) st_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        ctx_q[wcnt_q] <= mem_rdata;
                        wcnt_q        <= wcnt_q + 2'd1;
                        if (wcnt_q == 2'd3) begin
                            held_ch_q <= tgt_q;
                            held_v_q  <= 1'b1;
                            st_q      <= ST_CHECK;
                        end
                    end
                end
                ST_CHECK: begin
                    if (ctx_q[W_CFG][CFG_EN] && ctx_q[W_LEN] != 32'd0) st_q <= ST_READ;
                    else                                               st_q <= ST_IDLE;
                end
                ST_READ: begin
                    if (mem_ack) begin
                        beat_q <= beat_rd;
                        st_q   <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        ctx_q[W_LEN] <= ctx_q[W_LEN] - 32'd1;
                        if (ctx_q[W_CFG][CFG_SINC]) ctx_q[W_SRC] <= ctx_q[W_SRC] + step;
                        if (ctx_q[W_CFG][CFG_DINC]) ctx_q[W_DST] <= ctx_q[W_DST] + step;
                        if (last_beat) ctx_q[W_CFG][CFG_EN] <= 1'b0;
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_desc_engine_chk.sv
// Checker for the DMA engine: memory handshake, beat lanes and the causes
// of done and overrun flags. Bound to every instance of the top module.
module dma_desc_engine_chk #(
    parameter int NCH = 12,
    parameter int AW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] trig,
    input logic           mem_req,
    input logic           mem_we,
    input logic           mem_ack,
    input logic [AW-1:0]  mem_addr,
    input logic [3:0]     mem_be,
    input logic [NCH-1:0] done_irq,
    input logic [NCH-1:0] ovr_flags
);

    // R14
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6
    beat_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                                 $countones(mem_be) == 4));

    // R8
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done_irq & ~$past(done_irq))) |-> $past(mem_req && mem_we && mem_ack));

    // R10
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ovr_flags & ~$past(ovr_flags))) |-> $past(|trig));

endmodule

bind dma_desc_engine dma_desc_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .done_irq  (done_irq),
    .ovr_flags (ovr_flags)
);

// File: tb/dma_desc_engine_test.sv
// Directed bench: one task per scenario, word-addressed memory model with
// optional acknowledge stalls, and a transaction log for traffic checks.
module dma_desc_engine_test;

    localparam int NCH = 12;
    localparam int AW  = 32;
    localparam int LOGN = 1024;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] trig = '0;
    logic           reg_wr = 1'b0;
    logic [1:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           mem_req, mem_we, mem_ack;
    logic [AW-1:0]  mem_addr;
    logic [31:0]    mem_wdata, mem_rdata;
    logic [3:0]     mem_be;
    logic [NCH-1:0] done_irq;

    logic [31:0] mem [0:511];
    logic [31:0] log_addr [0:LOGN-1];
    logic        log_we   [0:LOGN-1];
    int          lp = 0;
    logic        slow = 1'b0;
    logic [1:0]  cyc = '0;
    int          nchk = 0;
    int          nfail = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    dma_desc_engine #(.NCH(NCH), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .trig(trig),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .done_irq(done_irq)
    );

    assign mem_ack   = mem_req && (!slow || cyc == 2'd0);
    assign mem_rdata = mem[mem_addr[10:2]];

    // Memory model and transaction log
    always @(posedge clk) begin
        cyc <= cyc + 2'd1;
        if (rst_n && mem_req && mem_ack) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end
            if (lp < LOGN) begin
                log_addr[lp] <= mem_addr;
                log_we[lp]   <= mem_we;
                lp <= lp + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit is_desc(input logic [31:0] a);
        return a >= 32'h100 && a < 32'h1C0;
    endfunction

    // Count logged transactions from index s on: kind 0 desc rd, 1 desc wr, 2 data rd, 3 data wr
    function automatic int cnt(input int s, input int kind);
        int n = 0;
        for (int i = s; i < lp; i++) begin
            if (kind == 0 && is_desc(log_addr[i]) && !log_we[i]) n++;
            if (kind == 1 && is_desc(log_addr[i]) &&  log_we[i]) n++;
            if (kind == 2 && !is_desc(log_addr[i]) && !log_we[i]) n++;
            if (kind == 3 && !is_desc(log_addr[i]) &&  log_we[i]) n++;
        end
        return n;
    endfunction

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_desc(input int ch, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] l, input logic [31:0] c);
        mem[64 + ch*4 + 0] = s;
        mem[64 + ch*4 + 1] = d;
        mem[64 + ch*4 + 2] = l;
        mem[64 + ch*4 + 3] = c;
    endtask

    task automatic pulse(input logic [NCH-1:0] m, input int ncyc);
        @(negedge clk);
        trig = m;
        repeat (ncyc) @(negedge clk);
        trig = '0;
    endtask

    task automatic settle();
        repeat (60) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        chk("R1 done", 32'(done_irq), 32'd0);
        rd_reg(2'd0, v); chk("R1 base", v, 32'd0);
        rd_reg(2'd1, v); chk("R1 mask", v, 32'd0);
        rd_reg(2'd3, v); chk("R1 ovr", v, 32'd0);
    endtask

    task automatic t_setup();
        logic [31:0] v;
        wr_reg(2'd0, 32'h0000_010F);
        wr_reg(2'd1, 32'h0000_093F);
        rd_reg(2'd0, v); chk("R2 R13 base aligned", v, 32'h100);
        rd_reg(2'd1, v); chk("R13 mask", v, 32'h93F);
    endtask

    task automatic t_byte_copy();
        int s;
        logic [31:0] v;
        mem[9'h80] = 32'h4433_2211; mem[9'hC0] = '0; mem[9'hC1] = '0;
        set_desc(0, 32'h200, 32'h301, 32'd4, 32'h27);
        s = lp; pulse(12'h001, 1); settle();
        chk("R3 first desc reads", cnt(s, 0), 4);
        chk("R3 no writeback", cnt(s, 1), 0);
        chk("R2 slot 0 addr", log_addr[s], 32'h100);
        chk("R6 one read", cnt(s, 2), 1);
        chk("R6 one write", cnt(s, 3), 1);
        s = lp;
        for (int k = 0; k < 3; k++) begin pulse(12'h001, 1); settle(); end
        chk("R3 held channel desc traffic", cnt(s, 0) + cnt(s, 1), 0);
        chk("R6 R7 bytes lanes word0", mem[9'hC0], 32'h3322_1100);
        chk("R7 byte lane word1", mem[9'hC1], 32'h0000_0044);
        chk("R8 done ch0", 32'(done_irq), 32'h1);
        rd_reg(2'd1, v); chk("R8 mask bit cleared", v, 32'h93E);
    endtask

    task automatic t_swap();
        int s;
        logic [31:0] v;
        mem[9'h84] = 32'h0000_005A; mem[9'hC4] = 32'hFFFF_FFFF;
        set_desc(1, 32'h210, 32'h310, 32'd1, 32'h07);
        s = lp; pulse(12'h002, 1); settle();
        chk("R4 writeback count", cnt(s, 1), 4);
        chk("R4 writeback first", log_addr[s], 32'h100);
        chk("R4 then fetch", log_addr[s+4], 32'h110);
        chk("R4 fetch count", cnt(s, 0), 4);
        chk("R4 R7 saved src", mem[64], 32'h204);
        chk("R4 R7 saved dst", mem[65], 32'h305);
        chk("R4 saved len", mem[66], 32'd0);
        chk("R4 R8 saved cfg", mem[67], 32'h26);
        chk("R6 byte enable", mem[9'hC4], 32'hFFFF_FF5A);
        chk("R8 no irq when bit5 clear", 32'(done_irq), 32'h1);
        rd_reg(2'd1, v); chk("R8 ch1 mask cleared", v, 32'h93C);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr_reg(2'd2, 32'h1);
        chk("R13 done cleared", 32'(done_irq), 32'h0);
        rd_reg(2'd2, v); chk("R13 done reg", v, 32'h0);
    endtask

    task automatic t_word_fixed();
        mem[9'h90] = 32'hA1B2_C3D4; mem[9'hD0] = '0; mem[9'hD1] = '0;
        set_desc(2, 32'h240, 32'h340, 32'd2, 32'h35);
        pulse(12'h004, 1); settle();
        pulse(12'h004, 1); settle();
        chk("R5 R7 fixed src word0", mem[9'hD0], 32'hA1B2_C3D4);
        chk("R5 R7 fixed src word1", mem[9'hD1], 32'hA1B2_C3D4);
        chk("R8 done ch2", 32'(done_irq), 32'h4);
    endtask

    task automatic t_priority();
        int s;
        int first;
        mem[9'h88] = 32'h0000_7700; mem[9'hC8] = '0;
        mem[9'h98] = 32'h1122_3344; mem[9'hD8] = '0; mem[9'hD9] = '0;
        set_desc(4, 32'h221, 32'h320, 32'd1, 32'h27);
        set_desc(5, 32'h260, 32'h362, 32'd2, 32'h2F);
        s = lp; pulse(12'h030, 1); settle();
        first = -1;
        for (int i = lp - 1; i >= s; i--) if (log_we[i] && !is_desc(log_addr[i])) first = i;
        chk("R9 lowest first", (first >= 0) ? log_addr[first] : 32'hDEAD, 32'h320);
        chk("R7 ch2 saved src fixed", mem[72], 32'h240);
        chk("R7 ch2 saved dst advanced", mem[73], 32'h348);
        pulse(12'h020, 1); settle();
        chk("R6 byte offset 1", mem[9'hC8], 32'h0000_0077);
        chk("R6 R7 half upper", mem[9'hD8], 32'h3344_0000);
        chk("R6 R7 half lower", mem[9'hD9], 32'h0000_1122);
        chk("R8 done ch4 ch5", 32'(done_irq), 32'h34);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        mem[9'h8C] = 32'h0D0C_0B0A; mem[9'hCC] = '0;
        set_desc(3, 32'h230, 32'h330, 32'd4, 32'h27);
        pulse(12'h008, 3); settle();
        rd_reg(2'd3, v); chk("R10 overrun ch3", v, 32'h8);
        chk("R10 two beats moved", mem[9'hCC], 32'h0000_0B0A);
        chk("R10 not done", 32'(done_irq), 32'h34);
        wr_reg(2'd3, 32'h8);
        rd_reg(2'd3, v); chk("R10 overrun cleared", v, 32'h0);
    endtask

    task automatic t_masked();
        int s;
        logic [31:0] v;
        set_desc(7, 32'h250, 32'h350, 32'd1, 32'h27);
        s = lp; pulse(12'h080, 2); settle();
        chk("R11 no traffic", lp - s, 0);
        rd_reg(2'd3, v); chk("R11 no overrun", v, 32'h0);
    endtask

    task automatic t_cfg_off();
        int s;
        logic [31:0] v;
        mem[9'hD4] = 32'h1234_5678;
        set_desc(8, 32'h250, 32'h350, 32'd3, 32'h26);
        s = lp; pulse(12'h100, 1); settle();
        chk("R12 descriptor loaded", cnt(s, 0), 4);
        chk("R12 no data beat", cnt(s, 2) + cnt(s, 3), 0);
        chk("R12 dst untouched", mem[9'hD4], 32'h1234_5678);
        rd_reg(2'd1, v); chk("R12 mask kept", v & 32'h100, 32'h100);
    endtask

    task automatic t_last_slow();
        int s;
        mem[9'hA0] = 32'hCAFE_F00D; mem[9'hE0] = '0;
        set_desc(11, 32'h280, 32'h380, 32'd1, 32'h35);
        slow = 1'b1;
        s = lp; pulse(12'h800, 1);
        repeat (120) @(negedge clk);
        slow = 1'b0;
        chk("R4 save ch8 slot", log_addr[s], 32'h180);
        chk("R2 slot 11 addr", log_addr[s+4], 32'h1B0);
        chk("R14 exact transfers under stall", lp - s, 10);
        chk("R14 data under stall", mem[9'hE0], 32'hCAFE_F00D);
        chk("R8 done ch11", 32'(done_irq), 32'h834);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_byte_copy();
        t_swap();
        t_w1c();
        t_word_fixed();
        t_priority();
        t_overrun();
        t_masked();
        t_cfg_off();
        t_last_slow();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule